// File: doc/BRIEF.md
# Four-Lane Parallel FIR Filter

This block runs one finite impulse response filter over a sample stream that arrives four samples per clock. Every clock may carry one 64-bit word holding four consecutive signed 16-bit samples. The block returns four filtered samples per accepted word, packed the same way. Taken together, the output lanes are the same sequence that a serial FIR would produce if it were fed the stream one sample at a time. For example, it can filter a 288 Msps stream on a 72 MHz clock without a faster clock.

Each output lane is a full sum of products over the current word and the held previous words. A tap reaching back past lane 0 of the current word reads the matching sample of an earlier word. The tap count, the coefficients, the output width and the scaling shift are elaboration-time parameters. Each sum is formed at full precision, arithmetically shifted right, and clamped symmetrically to the output width.

Top module: `fir4_lanes_top`

## Requirements
- R1: Input lane i occupies bits [16i+15:16i] of `in_data` as a signed 16-bit sample, and lane 0 is the oldest sample of the word, so consecutive words carry s0..s3, then s4..s7.
- R2: For an accepted word n, output lane k equals sat(floor(sum over j=0..NTAPS-1 of h[j]·x[4n+k−j] / 2^SHIFT)), with h[j] the signed 16-bit field at bits [16j+15:16j] of `COEFS`.
- R3: Taps that reach before lane 0 of the current word read samples of earlier accepted words, up to NTAPS−1 samples back, across word boundaries.
- R4: Products are summed at 32+ceil(log2 NTAPS) bits, so that no combination of extreme inputs wraps the sum before scaling.
- R5: The scaled value is clamped to ±(2^(OUT_W−1)−1). The value −2^(OUT_W−1) is never produced.
- R6: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the matching result is on `out_data` in that cycle.
- R7: While `in_valid` is low, the tap history does not advance and `out_data` holds its last value, so a gap inserts no samples into the stream.
- R8: A synchronous reset clears the history to zero and sets `out_valid` and `out_data` to zero, so the first words after reset see zero-padded history.
- R9: Output lane k occupies bits [OUT_W·k+OUT_W−1:OUT_W·k] of `out_data`, with the same oldest-in-lane-0 order as the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` this cycle |
| in_data | input | 64 | Four packed signed 16-bit samples, oldest in lane 0 |
| out_valid | output | 1 | Qualifies `out_data` |
| out_data | output | 4·OUT_W | Four packed filtered samples, oldest in lane 0 |

## Verification
The bench feeds an impulse into lane 0. The response must walk across lanes and into later words. A design that filtered each lane on its own, or that dropped the history at word boundaries, would show coefficients in the wrong lanes or miss them. Full-scale inputs of both signs are chosen to match the coefficient signs. They drive the sum far past the output range, which exposes wrapping sums and a clamp to −32768 instead of the symmetric limit. Random gaps in `in_valid` would catch a history that shifts on idle cycles. A reset applied mid-stream would catch stale history leaking into the first words after reset.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
  localparam int SAMP_W = 16;
  localparam int LANES  = 4;
  localparam int WORD_W = SAMP_W * LANES;

  // Arithmetic shift right (floor), then clamp to +/-(2^(ow-1)-1).
  function automatic logic signed [63:0] shift_sat(input logic signed [63:0] acc,
                                                   input int sh, input int ow);
    logic signed [63:0] s;
    logic signed [63:0] lim;
    s   = acc >>> sh;
    lim = (64'sd1 <<< (ow - 1)) - 64'sd1;
    if (s > lim)  return lim;
    if (s < -lim) return -lim;
    return s;
  endfunction
endpackage

// File: rtl/fir4_history.sv
module fir4_history
  import fir4_pkg::*;
#(
  parameter int HW = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv,
  input  logic [WORD_W-1:0]           word,
  output logic [(HW+1)*WORD_W-1:0]    win_flat,
  output logic [HW*WORD_W-1:0]        hist_state
);
  logic [HW*WORD_W-1:0] hist_q;

  // Highest slot is the current word; slot 0 is the oldest held word.
  assign win_flat   = {word, hist_q};
  assign hist_state = hist_q;

  always_ff @(posedge clk) begin
    if (rst)      hist_q <= '0;
    else if (adv) hist_q <= win_flat[(HW+1)*WORD_W-1:WORD_W];
  end
endmodule

// File: rtl/fir4_lane.sv
module fir4_lane
  import fir4_pkg::*;
#(
  parameter int                       NTAPS = 8,
  parameter logic [NTAPS*SAMP_W-1:0]  COEFS = '0,
  parameter int                       HW    = 2,
  parameter int                       K     = 0,
  parameter int                       SHIFT = 14,
  parameter int                       OUT_W = 16,
  localparam int                      ACC_W = 32 + $clog2(NTAPS)
) (
  input  logic [(HW+1)*WORD_W-1:0] win_flat,
  output logic [OUT_W-1:0]         y
);
  localparam int BASE = LANES * HW + K;

  logic signed [ACC_W-1:0] acc;

  always_comb begin
    logic signed [SAMP_W-1:0]   c;
    logic signed [SAMP_W-1:0]   x;
    logic signed [2*SAMP_W-1:0] p;
    acc = '0;
    for (int j = 0; j < NTAPS; j++) begin
      c   = COEFS[SAMP_W*j +: SAMP_W];
      x   = win_flat[SAMP_W*(BASE-j) +: SAMP_W];
      p   = c * x;
      acc = acc + ACC_W'(p);
    end
    y = OUT_W'(shift_sat(64'(acc), SHIFT, OUT_W));
  end
endmodule

// File: rtl/fir4_lanes_top.sv
module fir4_lanes_top
  import fir4_pkg::*;
#(
  parameter int                      NTAPS = 8,
  parameter logic [NTAPS*SAMP_W-1:0] COEFS = 128'h00FA_01F4_FA24_1770_1F40_0BB8_F830_03E8,
  parameter int                      SHIFT = 14,
  parameter int                      OUT_W = 16,
  localparam int                     HW    = (NTAPS - 1 + LANES - 1) / LANES,
  localparam int                     OUT_BUS = LANES * OUT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_data,
  output logic               out_valid,
  output logic [OUT_BUS-1:0] out_data
);
  logic [(HW+1)*WORD_W-1:0] win_flat;
  logic [HW*WORD_W-1:0]     hist_state;
  logic [OUT_BUS-1:0]       lane_y;

  fir4_history #(.HW(HW)) u_hist (
    .clk(clk), .rst(rst), .adv(in_valid), .word(in_data),
    .win_flat(win_flat), .hist_state(hist_state)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fir4_lane #(
      .NTAPS(NTAPS), .COEFS(COEFS), .HW(HW), .K(k),
      .SHIFT(SHIFT), .OUT_W(OUT_W)
    ) u_lane (
      .win_flat(win_flat),
      .y(lane_y[OUT_W*k +: OUT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= lane_y;
    end
  end
endmodule

// File: rtl/fir4_lanes_chk.sv
module fir4_lanes_chk #(
  parameter int OUT_W  = 16,
  parameter int HBITS  = 128,
  parameter int WORD_W = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [WORD_W-1:0]    in_data,
  input logic                 out_valid,
  input logic [4*OUT_W-1:0]   out_data,
  input logic [HBITS-1:0]     hist_state
);
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_no_valid_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_idle_hold_out_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  p_idle_hold_hist_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(hist_state));
  p_newest_enters_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> hist_state[HBITS-1 -: WORD_W] == $past(in_data));

  for (genvar k = 0; k < 4; k++) begin : g_sat
    p_no_min_code_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_data[OUT_W*k +: OUT_W] != {1'b1, {(OUT_W-1){1'b0}}});
  end
endmodule

bind fir4_lanes_top fir4_lanes_chk #(
  .OUT_W(OUT_W), .HBITS(HW*WORD_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .hist_state(hist_state)
);

// File: tb/fir4_lanes_top_tb.sv
module fir4_lanes_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  int coef [8] = '{1000, -2000, 3000, 8000, 6000, -1500, 500, 250};
  int smp [0:4095];
  int nsmp = 0;
  logic [63:0] last_out = '0;

  always #5 clk = ~clk;

  fir4_lanes_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Serial reference: one output sample at stream index idx.
  function automatic int ref_out(int idx);
    longint acc = 0;
    longint q;
    for (int j = 0; j < 8; j++)
      if (idx - j >= 0) acc += longint'(coef[j]) * longint'(smp[idx - j]);
    q = acc >>> 14;
    if (q > 32767)  q = 32767;
    if (q < -32767) q = -32767;
    return int'(q);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one word, then check the result one cycle later (R1,R2,R6,R9).
  task automatic push_word(input logic [63:0] w);
    int base = nsmp;
    for (int i = 0; i < 4; i++) smp[nsmp + i] = int'($signed(w[16*i +: 16]));
    nsmp += 4;
    in_data  = w;
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b1, "R6", longint'(out_valid), 1);
    for (int k = 0; k < 4; k++) begin
      int e = ref_out(base + k);
      int a = int'($signed(out_data[16*k +: 16]));
      check(a == e, "R2/R9 lane", a, e);
    end
    last_out = out_data;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    in_data  = 64'hDEAD_BEEF_1234_5678;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R6 idle", longint'(out_valid), 0);
      check(out_data == last_out, "R7 hold", longint'(out_data[31:0]), longint'(last_out[31:0]));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(out_valid === 1'b0, "R8 valid", longint'(out_valid), 0);
    check(out_data == 64'd0, "R8 data", longint'(out_data[31:0]), 0);
    nsmp = 0;
    last_out = '0;
  endtask

  function automatic logic [63:0] pack4(int a, int b, int c, int d);
    return {d[15:0], c[15:0], b[15:0], a[15:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R3: impulse 2^14 in lane 0 walks across lanes and into later words.
    push_word(pack4(16384, 0, 0, 0));
    push_word(pack4(0, 0, 0, 0));
    push_word(pack4(0, 0, 0, 0));
    // Impulse in lane 3: taps reach across the boundary into the next words.
    push_word(pack4(0, 0, 0, 16384));
    idle(3);
    push_word(pack4(0, 0, 0, 0));
    push_word(pack4(0, 0, 0, 0));

    // R4/R5: full-scale inputs matched to coefficient signs.
    for (int i = 0; i < 3; i++) push_word(pack4(32767, -32768, 32767, 32767));
    for (int i = 0; i < 3; i++) push_word(pack4(-32768, 32767, -32768, -32768));
    for (int i = 0; i < 3; i++) push_word(pack4(32767, 32767, -32768, 32767));

    // R8: reset mid-stream, then history must be zero.
    do_reset();
    push_word(pack4(100, -200, 300, -400));
    push_word(pack4(16384, 0, 0, 0));

    // Random stream with random gaps (R2, R3, R7).
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
      if (($urandom % 8) == 0)
        push_word(pack4(($urandom % 2) ? 32767 : -32768, ($urandom % 2) ? 32767 : -32768,
                        ($urandom % 2) ? 32767 : -32768, ($urandom % 2) ? 32767 : -32768));
      else
        push_word({$urandom, $urandom});
    end
    idle(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule